// File: doc/BRIEF.md
# Bidirectional Gate-Line Scan Shift Register

This block sequences the row (gate) lines of an active-matrix display. A single start pulse is captured on a rising edge of the shift clock and then walks through a chain of stages, one stage per rising edge. Each stage drives one gate-line enable, so exactly one row is selected at a time while a pulse is in flight. A direction input picks which end of the chain the pulse enters from and which way it travels. This lets the same block serve a panel that is scanned top-down or bottom-up.

The two start ports swap roles with the scan direction. The port at the entry end is an input. The port at the far end carries a cascade pulse that starts the next driver in a chain. Each port is modelled as a separate input, output and drive-enable. The cascade pulse is produced on falling clock edges, half a cycle after the last row lights, so that the downstream driver captures it cleanly on the following rising edge. A mask input blanks every gate line at once, without reference to the clock, and leaves the register contents untouched.

Top module: `gate_scan_shifter`

## Requirements
- R1: The block has STAGES stages (default 240), each driving one bit of `gate_line`. Bit 0 is line 1. After reset, every gate line is low.
- R2: With `dir_up` = 1, `start_r_in` is sampled on a rising clock edge. Line 1 goes high after that edge, and the pulse moves one line toward line STAGES on each later rising edge.
- R3: With `dir_up` = 0, `start_l_in` is sampled instead. Line STAGES goes high first, and the pulse moves one line toward line 1 on each later rising edge.
- R4: With `dir_up` = 1, `start_l_oe` = 1 and `start_r_oe` = 0. With `dir_up` = 0, the enables are swapped. The output of the port that is not driven stays 0.
- R5: The cascade output of the driven port rises on the falling edge of the STAGES-th clock after the start pulse is captured. It falls on the falling edge of the next clock.
- R6: When two instances are chained through the cascade port, at most one of the 2×STAGES lines is high per clock. The pulse crosses from the last line of the first driver to the first line of the second driver on consecutive clocks, in either direction.
- R7: While `out_mask` = 1, every gate line is low. This takes effect without waiting for a clock edge.
- R8: `out_mask` does not stop or clear the shifting. When it returns to 0, the line that would have been high without masking is high.
- R9: The synchronous active-low reset `rst_n` clears every stage and the cascade output, including a pulse that is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock. Stages move on the rising edge; the cascade pulse moves on the falling edge. |
| rst_n | input | 1 | Synchronous active-low reset. |
| dir_up | input | 1 | Scan direction: 1 moves the pulse from line 1 toward line STAGES, 0 moves it the other way. |
| out_mask | input | 1 | Asynchronous blanking of all gate lines. |
| start_r_in | input | 1 | Right start port, input side. |
| start_r_out | output | 1 | Right start port, cascade side. |
| start_r_oe | output | 1 | Drive-enable of the right start port. |
| start_l_in | input | 1 | Left start port, input side. |
| start_l_out | output | 1 | Left start port, cascade side. |
| start_l_oe | output | 1 | Drive-enable of the left start port. |
| gate_line | output | STAGES | Gate-line enables, one per stage. |

## Verification
The bench keeps the default of 240 stages and builds two instances linked through their start ports. This creates a 480-line chain, so a full traversal is observed in both directions. The hand-over at the 240/241 boundary and the cascade at the end of the chain are also checked. With the full-size chain, the cascade timing at the real stage count is checked directly rather than being extrapolated from a small instance. The mask is toggled at offsets that are not on a clock edge, in the middle of a scan. The bench checks that the lines go dark immediately and that the correct line reappears afterwards.

// File: rtl/gsc_pkg.sv
// Shared types for the gate scan shifter.
// Assumes: nothing beyond IEEE 1800-2017.
package gsc_pkg;

    // Scan direction, encoded exactly as the dir_up pin.
    typedef enum logic {
        SCAN_DOWN = 1'b0,   // pulse travels from the last line toward line 1
        SCAN_UP   = 1'b1    // pulse travels from line 1 toward the last line
    } scan_dir_e;

endpackage

// File: rtl/gsc_shift_core.sv
// Bidirectional shift register holding the scan pulse, one bit per gate line.
// Assumes: STAGES >= 2. The direction is held stable while a pulse is in flight.
module gsc_shift_core #(
    parameter int STAGES = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_up,
    input  logic              shift_in,
    output logic [STAGES-1:0] stage_q
);
    import gsc_pkg::*;

    localparam int LAST = STAGES - 1;

    scan_dir_e         dir;
    logic [STAGES-1:0] stage_d;

    // Decode the direction pin into the shared enum.
    always_comb dir = scan_dir_e'(dir_up);

    // Each stage takes its lower or upper neighbour; the end stages take the start input.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic from_low;
        logic from_high;
        if (i == 0) begin : g_low_end
            assign from_low = shift_in;
        end else begin : g_low_mid
            assign from_low = stage_q[i-1];
        end
        if (i == LAST) begin : g_high_end
            assign from_high = shift_in;
        end else begin : g_high_mid
            assign from_high = stage_q[i+1];
        end
        assign stage_d[i] = (dir == SCAN_UP) ? from_low : from_high;
    end

    // Register update on the rising edge, with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    AST_UP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        dir_up |=> stage_q[0] == $past(shift_in)); // R2
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        dir_up |=> stage_q[1] == $past(stage_q[0])); // R2
    AST_DOWN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_up |=> stage_q[LAST] == $past(shift_in)); // R3
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_up |=> stage_q[0] == $past(stage_q[1])); // R3

endmodule

// File: rtl/gsc_cascade.sv
// Cascade pulse generator: copies the exit stage on the falling clock edge,
// so the pulse is high from the falling edge of clock STAGES to that of clock STAGES+1.
// Assumes: the direction is only changed while the register is idle or in reset.
module gsc_cascade #(
    parameter int STAGES = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_up,
    input  logic [STAGES-1:0] stage_q,
    output logic              casc_q
);
    localparam int LAST = STAGES - 1;

    logic exit_bit;

    // Pick the stage at the far end of the current scan direction.
    always_comb exit_bit = dir_up ? stage_q[LAST] : stage_q[0];

    // Half-cycle retiming of the exit stage, cleared by the synchronous reset.
    always_ff @(negedge clk) begin
        if (!rst_n) casc_q <= 1'b0;
        else        casc_q <= exit_bit;
    end

    AST_CASC_TRACKS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        casc_q == exit_bit); // R5

endmodule

// File: rtl/gsc_port_mux.sv
// Steers the two start ports: the port at the entry end feeds the register,
// and the port at the exit end drives the cascade pulse.
// Assumes: an undriven port is read as the input.
module gsc_port_mux (
    input  logic dir_up,
    input  logic r_in,
    input  logic l_in,
    input  logic casc,
    output logic r_out,
    output logic r_oe,
    output logic l_out,
    output logic l_oe,
    output logic shift_in
);
    // Role assignment of both ports from the scan direction (R4).
    always_comb begin
        l_oe     = dir_up;
        r_oe     = !dir_up;
        l_out    = dir_up ? casc : 1'b0;
        r_out    = dir_up ? 1'b0 : casc;
        shift_in = dir_up ? r_in : l_in;
    end

endmodule

// File: rtl/gate_scan_shifter.sv
// Top level of the gate scan shifter: shift core, cascade generator, port steering
// and asynchronous output blanking.
// Assumes: out_mask may change at any time; every other input is synchronous to clk.
module gate_scan_shifter #(
    parameter int STAGES = 240
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_up,
    input  logic              out_mask,
    input  logic              start_r_in,
    output logic              start_r_out,
    output logic              start_r_oe,
    input  logic              start_l_in,
    output logic              start_l_out,
    output logic              start_l_oe,
    output logic [STAGES-1:0] gate_line
);
    logic [STAGES-1:0] stage_q;
    logic              shift_in;
    logic              casc_q;

    gsc_port_mux u_ports (
        .dir_up   (dir_up),
        .r_in     (start_r_in),
        .l_in     (start_l_in),
        .casc     (casc_q),
        .r_out    (start_r_out),
        .r_oe     (start_r_oe),
        .l_out    (start_l_out),
        .l_oe     (start_l_oe),
        .shift_in (shift_in)
    );

    gsc_shift_core #(.STAGES(STAGES)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_up   (dir_up),
        .shift_in (shift_in),
        .stage_q  (stage_q)
    );

    gsc_cascade #(.STAGES(STAGES)) u_casc (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_up  (dir_up),
        .stage_q (stage_q),
        .casc_q  (casc_q)
    );

    // Combinational blanking: the mask gates the lines, not the register (R7, R8).
    always_comb gate_line = out_mask ? '0 : stage_q;

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_line) || $past(!rst_n)); // R6
    AST_PORT_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({start_r_oe, start_l_oe}) == 1); // R4

endmodule

// File: tb/gate_scan_shifter_test.sv
`timescale 1ns/100ps
// Scoreboard bench: two chained instances, the driver pushes the expected chain state
// for every clock, and the monitor compares it 1 ns after each rising edge.
module gate_scan_shifter_test;
    localparam int N = 240;
    localparam int L = 2 * N;

    typedef struct packed {
        logic [L-1:0] lines;
        logic         link;
        logic         tail;
    } exp_t;

    exp_t sb_q[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_up = 1'b1;
    logic out_mask = 1'b0;
    logic stim_r = 1'b0;
    logic stim_l = 1'b0;
    int   checks = 0;
    int   errors = 0;

    logic         a_r_out, a_r_oe, a_l_out, a_l_oe, a_l_in;
    logic         b_r_out, b_r_oe, b_l_out, b_l_oe, b_r_in;
    logic [N-1:0] a_gate, b_gate;
    logic [L-1:0] chain;
    logic         link_w, tail_w;

    always #2.5 clk = ~clk;

    // Model of the shared wires between the two drivers.
    assign a_l_in = b_r_oe ? b_r_out : 1'b0;
    assign b_r_in = a_l_oe ? a_l_out : 1'b0;
    assign chain  = {b_gate, a_gate};
    assign link_w = dir_up ? a_l_out : b_r_out;
    assign tail_w = dir_up ? b_l_out : a_r_out;

    gate_scan_shifter #(.STAGES(N)) uut (
        .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .out_mask(out_mask),
        .start_r_in(stim_r), .start_r_out(a_r_out), .start_r_oe(a_r_oe),
        .start_l_in(a_l_in), .start_l_out(a_l_out), .start_l_oe(a_l_oe),
        .gate_line(a_gate)
    );

    gate_scan_shifter #(.STAGES(N)) uut_next (
        .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .out_mask(out_mask),
        .start_r_in(b_r_in), .start_r_out(b_r_out), .start_r_oe(b_r_oe),
        .start_l_in(stim_l), .start_l_out(b_l_out), .start_l_oe(b_l_oe),
        .gate_line(b_gate)
    );

    task automatic check(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s", msg);
        end
    endtask

    // Driver: one start pulse, then one expected chain state per rising edge.
    task automatic run_scan(input bit up);
        for (int k = 1; k <= L + 2; k++) begin
            exp_t e;
            @(negedge clk);
            if (up) stim_r = (k == 1);
            else    stim_l = (k == 1);
            e.lines = '0;
            if (k <= L) e.lines[up ? k - 1 : L - k] = 1'b1;
            e.link = (k == N + 1);
            e.tail = (k == L + 1);
            sb_q.push_back(e);
        end
        @(negedge clk);
        stim_r = 1'b0;
        stim_l = 1'b0;
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    // Monitor: compare the chain against the scoreboard after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t         e;
            logic [L-1:0] want;
            e    = sb_q.pop_front();
            want = out_mask ? '0 : e.lines;
            check(chain == want, $sformatf("R6/R2/R3/R8 lines act=%h exp=%h mask=%0b", chain, want, out_mask));
            check($countones(chain) <= 1, $sformatf("R6 one-hot act=%0d exp<=1", $countones(chain)));
            check(link_w == e.link, $sformatf("R5 link cascade act=%0b exp=%0b", link_w, e.link));
            check(tail_w == e.tail, $sformatf("R5 tail cascade act=%0b exp=%0b", tail_w, e.tail));
        end
    end

    // Blanking at an offset that is not on a clock edge, during a scan.
    task automatic mask_window(input int at_edge, input real offs);
        repeat (at_edge) @(posedge clk);
        #(offs) out_mask = 1'b1;
        #0.2;
        check(chain == '0, $sformatf("R7 async blank act=%h exp=0", chain));
        repeat (3) @(posedge clk);
        #(offs) out_mask = 1'b0;
    endtask

    task automatic reset_to(input bit up);
        @(negedge clk);
        rst_n  = 1'b0;
        dir_up = up;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        reset_to(1'b1);
        #1;
        check(chain == '0, $sformatf("R1 reset lines act=%h exp=0", chain));
        check(link_w == 1'b0 && tail_w == 1'b0, $sformatf("R9 reset cascade act=%0b%0b exp=00", link_w, tail_w));
        check(a_l_oe == 1'b1 && a_r_oe == 1'b0, $sformatf("R4 up roles act=l%0b r%0b exp=l1 r0", a_l_oe, a_r_oe));
        check(a_r_out == 1'b0, $sformatf("R4 undriven out act=%0b exp=0", a_r_out));

        // R2, R5, R6 upward scan with R7/R8 blanking at two odd offsets.
        fork
            run_scan(1'b1);
            begin
                mask_window(100, 2.3);
                mask_window(139, 3.7);
            end
        join

        // R3, R5, R6 downward scan.
        reset_to(1'b0);
        #1;
        check(b_r_oe == 1'b1 && b_l_oe == 1'b0, $sformatf("R4 down roles act=r%0b l%0b exp=r1 l0", b_r_oe, b_l_oe));
        check(b_l_out == 1'b0, $sformatf("R4 undriven out act=%0b exp=0", b_l_out));
        run_scan(1'b0);

        // R9: reset while the cascade pulse is high.
        reset_to(1'b1);
        @(negedge clk);
        stim_r = 1'b1;
        @(negedge clk);
        stim_r = 1'b0;
        repeat (N - 1) @(negedge clk);
        #0.5;
        check(link_w == 1'b1, $sformatf("R5 link high before reset act=%0b exp=1", link_w));
        rst_n = 1'b0;
        @(negedge clk);
        #0.5;
        check(link_w == 1'b0, $sformatf("R9 link cleared act=%0b exp=0", link_w));
        check(chain == '0, $sformatf("R9 lines cleared act=%h exp=0", chain));
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(chain == '0 && tail_w == 1'b0, $sformatf("R9 stays idle act=%h exp=0", chain));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL R1 watchdog act=running exp=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule